// File: doc/BRIEF.md
# MDIO Management Master with Responder Tracking

This block lets software talk to external Ethernet PHYs over the two-wire management bus. Software sets up one command register in a single write. That write gives the PHY address, the register address, the direction and, for a write, the data word. A set go flag in the same write starts a clause-22 frame. The block divides the system clock down to make MDC. It shifts the frame out on the data line and releases the line where the PHY is expected to answer. It then samples the reply and places it back in the command register.

Every read also records whether the addressed PHY pulled the second turnaround bit low. That result goes into an acknowledge flag and into one bit of a 32-bit responder map indexed by PHY address. Software can poll the map to notice a PHY that has stopped answering. The data line is modelled as three signals: a driven value, an output enable and a sampled input.

Top module: `mdio_mgmt_master`

## Requirements
- R1: A command write (reg_sel=0) with bit 31 set starts a frame. Bit 31 reads back 1 for exactly 128·H system clocks after that write's clock edge, where H is the MDC half period. It then clears itself in the same cycle that MDC returns low.
- R2: Command register layout: bit 31 go, bit 30 write (1 = write frame, 0 = read frame), bit 29 acknowledge (read-only), bits 28:26 read as 0, bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data. A command write while idle loads all writable fields, with or without go.
- R3: A frame is driven MSB first, one bit per MDC period: 32 ones, then 01, then opcode 10 (read) or 01 (write), then the PHY address, the register address, two turnaround bits and 16 data bits.
- R4: A write frame drives turnaround 10 followed by the data field. The output enable stays asserted for all 64 bit periods.
- R5: A read frame releases the output enable from the first turnaround bit (bit 46) to the end of the frame. The 16 bits sampled on the MDC rising edges of bits 48..63 end up in data bits 15:0, MSB first, when go clears.
- R6: After a read, bit 29 is 1 if the line was sampled 0 on the rising MDC edge of the second turnaround bit, and 0 otherwise. A write frame leaves bit 29 at 0.
- R7: The responder map (reg_sel=1) has bit p equal to the acknowledge result of the most recent read to PHY address p. No other bit changes. Writes to the map have no effect.
- R8: The MDC half period H is max(mdc_half, 2) system clocks. MDC idles low. The driven data bit changes only together with a falling MDC edge, or when a frame starts.
- R9: A command write while go reads 1 is ignored. The frame in progress and all register fields are left unchanged.
- R10: After reset, go is 0, the responder map is all zeros, MDC is low and the output enable is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_half | input | DIV_W | MDC half period in system clocks (values below 2 act as 2) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command register, 1 the responder map |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_out | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_in | input | 1 | Value sampled from the data line |

## Verification
The bench runs write and read frames at several divider settings, including a setting below the minimum that must clamp. A wrong clamp or an off-by-one divider would skew MDC against the model in every cycle. It issues a second command in the middle of a frame; a design that accepts it would corrupt the shifted address bits or the final field readback. It also reads from a PHY that answers, then from one that never pulls the turnaround low, then from the first PHY after it goes silent. This catches a design that samples the acknowledge on the wrong turnaround bit, writes the wrong responder-map bit, or never clears a bit once set. Releasing the line one bit early or late on reads is caught by the output-enable comparison made every cycle.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;

    localparam int PHY_AW     = 5;
    localparam int REG_AW     = 5;
    localparam int DATA_W     = 16;
    localparam int PREAMBLE_N = 32;
    localparam int FRAME_LEN  = PREAMBLE_N + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int TA_POS     = PREAMBLE_N + 2 + 2 + PHY_AW + REG_AW;
    localparam int DATA_POS   = TA_POS + 2;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int NUM_PHY    = 2 ** PHY_AW;
    localparam int RSVD_W     = 32 - 3 - REG_AW - PHY_AW - DATA_W;

    typedef struct packed {
        logic              go;
        logic              wr;
        logic              ack;
        logic [RSVD_W-1:0] rsvd;
        logic [REG_AW-1:0] regad;
        logic [PHY_AW-1:0] phyad;
        logic [DATA_W-1:0] data;
    } cmd_reg_t;

    typedef enum logic { FS_IDLE, FS_RUN } frm_state_e;

    // Whole frame, first bit on the line in the MSB
    function automatic logic [FRAME_LEN-1:0] build_frame(
        input logic              wr,
        input logic [PHY_AW-1:0] phy,
        input logic [REG_AW-1:0] regad,
        input logic [DATA_W-1:0] data
    );
        logic [1:0]        opc;
        logic [1:0]        ta;
        logic [DATA_W-1:0] pay;
        opc = wr ? 2'b01 : 2'b10;
        ta  = wr ? 2'b10 : 2'b00;
        pay = wr ? data : '0;
        return {{PREAMBLE_N{1'b1}}, 2'b01, opc, phy, regad, ta, pay};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             tick;

    assign lim  = (half < MIN_HALF) ? MIN_HALF : half;
    assign tick = run && (cnt >= lim - DIV_W'(1));
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cmd_wr,
    input  logic [PHY_AW-1:0] cmd_phy,
    input  logic [REG_AW-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              mdc_rise,
    input  logic              mdc_fall,
    output logic              run,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ack
);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] REL_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] ACK_IDX   = IDX_W'(TA_POS + 1);
    localparam logic [IDX_W-1:0] FIRST_DAT = IDX_W'(DATA_POS);

    frm_state_e           state;
    logic [IDX_W-1:0]     idx;
    logic [FRAME_LEN-1:0] sr;
    logic                 is_wr;
    logic [DATA_W-1:0]    cap;
    logic                 ack_q;
    logic                 oe_q;

    assign run      = (state == FS_RUN);
    assign done     = run && mdc_fall && (idx == LAST_IDX);
    assign mdio_out = sr[FRAME_LEN-1];
    assign mdio_oe  = oe_q;
    assign rd_data  = cap;
    assign rd_ack   = ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_IDLE;
            idx   <= '0;
            sr    <= '0;
            is_wr <= 1'b0;
            cap   <= '0;
            ack_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            case (state)
                FS_IDLE: begin
                    if (start) begin
                        state <= FS_RUN;
                        idx   <= '0;
                        sr    <= build_frame(cmd_wr, cmd_phy, cmd_reg, cmd_data);
                        is_wr <= cmd_wr;
                        cap   <= '0;
                        ack_q <= 1'b0;
                        oe_q  <= 1'b1;
                    end
                end
                FS_RUN: begin
                    if (mdc_rise && !is_wr) begin
                        if (idx == ACK_IDX) begin
                            ack_q <= !mdio_in;
                        end
                        if (idx >= FIRST_DAT) begin
                            cap <= {cap[DATA_W-2:0], mdio_in};
                        end
                    end
                    if (mdc_fall) begin
                        if (idx == LAST_IDX) begin
                            state <= FS_IDLE;
                            idx   <= '0;
                            oe_q  <= 1'b0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                            sr  <= {sr[FRAME_LEN-2:0], 1'b0};
                            if (!is_wr && (idx + IDX_W'(1) == REL_IDX)) begin
                                oe_q <= 1'b0;
                            end
                        end
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] mdc_half,
    input  logic             reg_wr_en,
    input  logic             reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mdc,
    output logic             mdio_out,
    output logic             mdio_oe,
    input  logic             mdio_in
);
    cmd_reg_t           wcmd;
    logic               go_q;
    logic               wr_q;
    logic               ack_q;
    logic [REG_AW-1:0]  regad_q;
    logic [PHY_AW-1:0]  phy_q;
    logic [DATA_W-1:0]  data_q;
    logic [NUM_PHY-1:0] alive_q;

    logic               cmd_take;
    logic               start;
    logic               run;
    logic               mdc_rise;
    logic               mdc_fall;
    logic               frame_done;
    logic [DATA_W-1:0]  rd_data;
    logic               rd_ack;

    assign wcmd     = cmd_reg_t'(reg_wdata);
    assign cmd_take = reg_wr_en && !reg_sel && !go_q;
    assign start    = cmd_take && wcmd.go;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q    <= 1'b0;
            wr_q    <= 1'b0;
            ack_q   <= 1'b0;
            regad_q <= '0;
            phy_q   <= '0;
            data_q  <= '0;
            alive_q <= '0;
        end else if (cmd_take) begin
            wr_q    <= wcmd.wr;
            regad_q <= wcmd.regad;
            phy_q   <= wcmd.phyad;
            data_q  <= wcmd.data;
            if (wcmd.go) begin
                go_q  <= 1'b1;
                ack_q <= 1'b0;
            end
        end else if (frame_done) begin
            go_q <= 1'b0;
            if (!wr_q) begin
                data_q         <= rd_data;
                ack_q          <= rd_ack;
                alive_q[phy_q] <= rd_ack;
            end
        end
    end

    always_comb begin
        cmd_reg_t rv;
        rv.go    = go_q;
        rv.wr    = wr_q;
        rv.ack   = ack_q;
        rv.rsvd  = '0;
        rv.regad = regad_q;
        rv.phyad = phy_q;
        rv.data  = data_q;
        reg_rdata = reg_sel ? alive_q : rv;
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .half (mdc_half),
        .mdc  (mdc),
        .rise (mdc_rise),
        .fall (mdc_fall)
    );

    mdio_frame_engine u_frame (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd_wr   (wcmd.wr),
        .cmd_phy  (wcmd.phyad),
        .cmd_reg  (wcmd.regad),
        .cmd_data (wcmd.data),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall),
        .run      (run),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .mdio_in  (mdio_in),
        .done     (frame_done),
        .rd_data  (rd_data),
        .rd_ack   (rd_ack)
    );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_master_chk
    import mdio_mgmt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               reg_wr_en,
    input logic               reg_sel,
    input logic               mdc,
    input logic               mdio_out,
    input logic               mdio_oe,
    input logic               go,
    input logic               frame_done,
    input logic [NUM_PHY-1:0] alive,
    input logic [PHY_AW-1:0]  acc_phy
);
    AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(go) |-> $fell(mdc)); // R1

    AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !go |-> !mdio_oe); // R10

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !go |-> !mdc); // R8

    AST_OUT_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_out)); // R8

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (go && reg_wr_en && !reg_sel) |=> $stable(acc_phy)); // R9

    AST_MAP_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(alive) |-> $past(frame_done)); // R7
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr_en  (reg_wr_en),
    .reg_sel    (reg_sel),
    .mdc        (mdc),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe),
    .go         (go_q),
    .frame_done (frame_done),
    .alive      (alive_q),
    .acc_phy    (phy_q)
);

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mdc_half = 8'd2;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_alive = '0;

    always #2 clk = ~clk;

    mdio_mgmt_master u_mdio_mgmt_master (
        .clk(clk), .rst(rst), .mdc_half(mdc_half),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd(input logic go, input logic wr,
        input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        return {go, wr, 1'b0, 3'b000, ra, phy, d};
    endfunction

    // Runs one frame and compares against the behavioural model every clock
    task automatic run_frame(input logic wr, input logic [4:0] phy,
        input logic [4:0] ra, input logic [15:0] d, input logic answers,
        input logic [15:0] phy_data, input int lim, input logic poke);
        logic [63:0] vec;
        int total;
        vec = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra,
               (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0000)};
        total = 128 * lim;
        @(negedge clk);
        reg_sel = 1'b0;
        reg_wdata = cmd(1'b1, wr, phy, ra, d);
        reg_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
        for (int k = 0; k <= total; k++) begin
            int b;
            logic e_go, e_mdc, e_oe;
            b = k / (2 * lim);
            e_go = (k < total);
            e_mdc = (k < total) ? logic'((k / lim) % 2) : 1'b0;
            e_oe = (k < total) && (wr || b < 46);
            chk("R1", "go", {31'b0, reg_rdata[31]}, {31'b0, e_go});
            chk("R8", "mdc", {31'b0, mdc}, {31'b0, e_mdc});
            chk(wr ? "R4" : "R5", "oe", {31'b0, mdio_oe}, {31'b0, e_oe});
            if (e_oe) chk("R3", "bit", {31'b0, mdio_out}, {31'b0, vec[63 - b]});
            if (!wr && k < total && b == 47) mdio_in = !answers;
            else if (!wr && k < total && b >= 48 && answers) mdio_in = phy_data[15 - (b - 48)];
            else mdio_in = 1'b1;
            if (poke && k == 5) begin
                reg_wdata = cmd(1'b1, !wr, ~phy, ~ra, ~d);
                reg_wr_en = 1'b1;
            end
            if (poke && k == 6) reg_wr_en = 1'b0;
            @(negedge clk);
        end
        chk("R1", "go cleared", {31'b0, reg_rdata[31]}, 32'd0);
        chk(poke ? "R9" : "R2", "fields", {16'b0, reg_rdata[30], 5'b0, reg_rdata[25:16]},
            {16'b0, wr, 5'b0, ra, phy});
        chk("R6", "ack", {31'b0, reg_rdata[29]}, {31'b0, (!wr && answers)});
        chk(wr ? "R4" : "R5", "data", {16'b0, reg_rdata[15:0]},
            {16'b0, wr ? d : (answers ? phy_data : 16'hFFFF)});
        if (!wr) exp_alive[phy] = answers;
        reg_sel = 1'b1;
        #0;
        chk("R7", "alive", reg_rdata, exp_alive);
        reg_sel = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", "go", {31'b0, reg_rdata[31]}, 32'd0);
        chk("R10", "mdc", {31'b0, mdc}, 32'd0);
        chk("R10", "oe", {31'b0, mdio_oe}, 32'd0);
        reg_sel = 1'b1;
        #0;
        chk("R10", "alive", reg_rdata, 32'd0);
        // R7 writes to the map have no effect
        reg_wdata = 32'hFFFF_FFFF;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        chk("R7", "map write ignored", reg_rdata, 32'd0);
        reg_sel = 1'b0;
        // R2 idle write without go loads fields, starts nothing
        reg_wdata = cmd(1'b0, 1'b1, 5'd17, 5'd9, 16'hBEEF);
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        chk("R2", "layout", reg_rdata, 32'h4131_BEEF);
        repeat (4) @(negedge clk);
        chk("R2", "no start mdc", {31'b0, mdc}, 32'd0);
        chk("R2", "no start oe", {31'b0, mdio_oe}, 32'd0);

        run_frame(1'b1, 5'd5, 5'd3, 16'hA5C3, 1'b0, 16'h0, 2, 1'b1);   // R4 R9
        run_frame(1'b0, 5'd5, 5'd2, 16'h0000, 1'b1, 16'h1234, 2, 1'b0); // R5 R6
        run_frame(1'b0, 5'd9, 5'd1, 16'h0000, 1'b0, 16'h0, 2, 1'b0);   // R6 dead
        mdc_half = 8'd3;
        run_frame(1'b0, 5'd31, 5'd31, 16'h0000, 1'b1, 16'h8001, 3, 1'b1); // R8 H=3
        mdc_half = 8'd1;
        run_frame(1'b0, 5'd5, 5'd2, 16'h0000, 1'b0, 16'h0, 2, 1'b0);   // R7 dropout, R8 clamp
        run_frame(1'b1, 5'd0, 5'd0, 16'h0F0F, 1'b0, 16'h0, 2, 1'b0);   // R3 zero addresses

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule